// File: doc/BRIEF.md
# Dual-Timing Multiplexed Host Bus Slave Port

This block is the register-access port of a peripheral that sits on an 8-bit bus where address and data share the same lines. A host first puts a register address on the lines and pulses an address strobe. The port keeps the address that is on the lines when that strobe falls. In the second part of the cycle the host either writes a byte or reads one back. Inside the chip the port gives a plain register interface: an address, write data, a one-clock write enable, a one-clock read enable and a read-data return.

A static strap selects one of two host timing styles. With the strap low, the two strobe pins are separate active-low read and write strobes. With the strap high, the first pin is an active-high data strobe and the second is a direction level, high for read and low for write. All strobes pass through two-flop synchronisers into the system clock. The bus lines are delayed by a matching two-stage pipeline, so every bus sample lines up with the strobe state it belongs to. The bidirectional pad is modelled as an input path, an output path and an output enable.

A control state machine has five states:
- `ST_IDLE`: waiting for the first address strobe.
- `ST_ADDR`: the address strobe is high.
- `ST_ARMED`: an address is held.
- `ST_READ`: driving the bus.
- `ST_WRITE`: collecting write data.

It has these transitions:
- `ST_IDLE`→`ST_ADDR` when the strobe rises.
- `ST_ADDR`→`ST_ARMED` when it falls, and the address is latched at that point.
- `ST_ARMED`→`ST_ADDR` when a new address strobe arrives.
- `ST_ARMED`→`ST_READ` when a read strobe is asserted. Read takes priority over write.
- `ST_ARMED`→`ST_WRITE` when a write strobe is asserted.
- `ST_READ`→`ST_ARMED` when the read strobe ends, and the bus is released.
- `ST_WRITE`→`ST_ARMED` when the write strobe ends, and the write pulse is issued.

Top module: `mux_bus_port`

## Requirements
- R1: When `mode_i`=0, `strb_a_i` is an active-low read strobe and `strb_b_i` is an active-low write strobe. When `mode_i`=1, `strb_a_i` is an active-high data strobe and `strb_b_i` gives the direction (1 = read, 0 = write) while that strobe is high.
- R2: The register address is the value of `bus_in_i` when `ale_i` falls. Later changes on `bus_in_i` do not change `reg_addr_o`.
- R3: `reg_addr_o` stays stable throughout a read or write data phase.
- R4: A write captures the last `bus_in_i` value seen while the write strobe is asserted. When the strobe ends (write strobe rising in mode 0, data strobe falling in mode 1), the block presents that value on `reg_wdata_o` together with `reg_we_o`.
- R5: While a read strobe is asserted, `bus_oe_o`=1 and `bus_out_o` equals `reg_rdata_i`. `bus_oe_o` returns to 0 when the strobe ends (read strobe rising in mode 0, data strobe falling in mode 1).
- R6: Each write produces exactly one clock of `reg_we_o`. Each read produces exactly one clock of `reg_re_o`.
- R7: Addresses at or above `NUM_REGS` (default 4) are unimplemented. A read of such an address drives 0x00 and gives no `reg_re_o`. A write to such an address gives no `reg_we_o`, and the implemented registers are left unchanged.
- R8: `bus_oe_o` rises on the third rising clock edge after the read strobe pin becomes active: two synchroniser edges followed by one state-register edge.
- R9: After reset, `bus_oe_o`, `reg_we_o` and `reg_re_o` are 0 and `reg_addr_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | Timing strap: 0 = read/write strobe pair, 1 = data strobe with direction |
| ale_i | input | 1 | Address strobe; the address is taken on its falling edge |
| strb_a_i | input | 1 | Mode 0: read strobe (low active); mode 1: data strobe (high active) |
| strb_b_i | input | 1 | Mode 0: write strobe (low active); mode 1: direction (1 read, 0 write) |
| bus_in_i | input | 8 | Shared address/data lines, input path |
| bus_out_o | output | 8 | Shared lines, output path |
| bus_oe_o | output | 1 | Output enable for the shared lines |
| reg_addr_o | output | 8 | Latched register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-clock register write enable |
| reg_re_o | output | 1 | One-clock register read enable |
| reg_rdata_i | input | 8 | Register read data |

## Verification
A pin change reaches the state register on the third rising edge after the change. The bench drives pins on falling edges and, for R8, samples `bus_oe_o` at the falling edge after two rising edges (expected 0) and again after the third (expected 1). The write pulse comes one edge after the synchronised strobe release and lasts one clock. A monitor on rising edges therefore counts the high cycles of `reg_we_o` and `reg_re_o`, and the tasks compare those counts only after waiting at least six clocks past the strobe release. Address, read-data and release checks are likewise taken after a settle wait of four or more clocks, which is always longer than the three-edge path.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ARMED,
        ST_READ,
        ST_WRITE
    } bus_state_t;

    localparam logic MODE_STROBE_PAIR = 1'b0;
    localparam logic MODE_DATA_STROBE = 1'b1;
endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbp_strobe_map.sv
module mbp_strobe_map
    import mbp_pkg::*;
(
    input  logic mode_i,
    input  logic strb_a_s,
    input  logic strb_b_s,
    output logic rd_act_o,
    output logic wr_act_o
);
    always_comb begin
        if (mode_i == MODE_DATA_STROBE) begin
            rd_act_o = strb_a_s &  strb_b_s;
            wr_act_o = strb_a_s & ~strb_b_s;
        end else begin
            rd_act_o = ~strb_a_s;
            wr_act_o = ~strb_b_s & strb_a_s;
        end
    end
endmodule

// File: rtl/mbp_ctrl.sv
module mbp_ctrl
    import mbp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NUM_REGS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_s,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic [DW-1:0] bus_d,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o,
    output logic          re_o,
    output logic [DW-1:0] bus_out_o,
    output logic          bus_oe_o
);
    localparam logic [DW-1:0] LIMIT = DW'(NUM_REGS);

    bus_state_t    state_q, state_d;
    logic [DW-1:0] addr_q, wdata_q;
    logic          we_q, re_q;
    logic          hit;

    assign hit = (addr_q < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ale_s)       state_d = ST_ADDR;
            ST_ADDR:  if (!ale_s)      state_d = ST_ARMED;
            ST_ARMED: begin
                if (ale_s)             state_d = ST_ADDR;
                else if (rd_act)       state_d = ST_READ;
                else if (wr_act)       state_d = ST_WRITE;
            end
            ST_READ:  if (!rd_act)     state_d = ST_ARMED;
            ST_WRITE: if (!wr_act)     state_d = ST_ARMED;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            re_q    <= 1'b0;
        end else begin
            if (state_q == ST_ADDR && !ale_s)
                addr_q <= bus_d;
            if (state_q == ST_WRITE && wr_act)
                wdata_q <= bus_d;
            we_q <= (state_q == ST_WRITE) && !wr_act && hit;
            re_q <= (state_q == ST_ARMED) && !ale_s && rd_act && hit;
        end
    end

    always_comb begin
        addr_o    = addr_q;
        wdata_o   = wdata_q;
        we_o      = we_q;
        re_o      = re_q;
        bus_oe_o  = (state_q == ST_READ);
        bus_out_o = (bus_oe_o && hit) ? rdata_i : '0;
    end

    AST_WE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) we_o |=> !we_o);                        // R6
    AST_RE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) re_o |=> !re_o);                        // R6
    AST_WE_IMPL:    assert property (@(posedge clk) disable iff (!rst_n) we_o |-> (addr_o < LIMIT));             // R7
    AST_RE_IMPL:    assert property (@(posedge clk) disable iff (!rst_n) re_o |-> (addr_o < LIMIT));             // R7
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(rd_act) |=> !bus_oe_o);            // R5
    AST_ADDR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (bus_oe_o && $past(bus_oe_o)) |-> $stable(addr_o)); // R3
    AST_NO_WE_READ: assert property (@(posedge clk) disable iff (!rst_n) bus_oe_o |-> !we_o);                    // R4
endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
    import mbp_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NUM_REGS = 4,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          ale_i,
    input  logic          strb_a_i,
    input  logic          strb_b_i,
    input  logic [DW-1:0] bus_in_i,
    output logic [DW-1:0] bus_out_o,
    output logic          bus_oe_o,
    output logic [DW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_we_o,
    output logic          reg_re_o,
    input  logic [DW-1:0] reg_rdata_i
);
    logic [2:0]    pins_s;
    logic [DW-1:0] bus_d;
    logic          rd_act, wr_act;

    mbp_sync #(.WIDTH(3), .STAGES(SYNC_LEN)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ale_i, strb_a_i, strb_b_i}),
        .q_o   (pins_s)
    );

    mbp_sync #(.WIDTH(DW), .STAGES(SYNC_LEN)) u_bus_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_in_i),
        .q_o   (bus_d)
    );

    mbp_strobe_map u_map (
        .mode_i   (mode_i),
        .strb_a_s (pins_s[1]),
        .strb_b_s (pins_s[0]),
        .rd_act_o (rd_act),
        .wr_act_o (wr_act)
    );

    mbp_ctrl #(.DW(DW), .NUM_REGS(NUM_REGS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale_s     (pins_s[2]),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .bus_d     (bus_d),
        .rdata_i   (reg_rdata_i),
        .addr_o    (reg_addr_o),
        .wdata_o   (reg_wdata_o),
        .we_o      (reg_we_o),
        .re_o      (reg_re_o),
        .bus_out_o (bus_out_o),
        .bus_oe_o  (bus_oe_o)
    );
endmodule

// File: tb/test_mux_bus_port.sv
module test_mux_bus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b0;
    logic       ale = 1'b0;
    logic       sa = 1'b1;
    logic       sb = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, reg_addr, reg_wdata, reg_rdata;
    logic       bus_oe, reg_we, reg_re;

    int checks = 0;
    int fails  = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    bit done   = 0;
    logic [7:0] regs [4];
    logic [7:0] shadow [4];

    always #2.5 clk = ~clk;

    mux_bus_port i_mux_bus_port (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ale_i(ale),
        .strb_a_i(sa), .strb_b_i(sb), .bus_in_i(bus_in),
        .bus_out_o(bus_out), .bus_oe_o(bus_oe), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_re_o(reg_re),
        .reg_rdata_i(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr[1:0]];

    always @(posedge clk) begin
        if (reg_we) begin
            we_cnt <= we_cnt + 1;
            if (reg_addr < 8'd4) regs[reg_addr[1:0]] <= reg_wdata;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reset_mode(input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        mode = m;
        ale = 1'b0;
        sa = m ? 1'b0 : 1'b1;
        sb = 1'b1;
        waitc(3);
        rst_n = 1'b1;
        waitc(3);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        bus_in = a;
        ale = 1'b1;
        waitc(4);
        ale = 1'b0;
        waitc(4);
        bus_in = ~a;   // the value on the lines changes after the strobe
        waitc(4);
        chk("R2 address latched at strobe fall", reg_addr, a);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
        int we0;
        addr_phase(a);
        we0 = we_cnt;
        bus_in = d ^ 8'h5A;
        sb = 1'b0;
        if (mode) begin waitc(2); sa = 1'b1; end
        waitc(2);
        bus_in = d;       // last value before the release counts
        waitc(4);
        if (mode) sa = 1'b0; else sb = 1'b1;
        waitc(1);
        bus_in = 8'hEE;
        if (mode) sb = 1'b1;
        waitc(6);
        if (a < 8'd4) begin
            chk({tag, " R6 one write pulse"}, we_cnt - we0, 1);
            chk({tag, " R4 write data"}, reg_wdata, d);
            shadow[a[1:0]] = d;
        end else begin
            chk({tag, " R7 no write pulse"}, we_cnt - we0, 0);
        end
        chk({tag, " R3 address kept"}, reg_addr, a);
    endtask

    task automatic do_read(input logic [7:0] a, input string tag);
        int re0;
        logic [7:0] exp;
        exp = (a < 8'd4) ? shadow[a[1:0]] : 8'h00;
        addr_phase(a);
        re0 = re_cnt;
        if (mode) sa = 1'b1; else sa = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({tag, " R8 no drive after two edges"}, bus_oe, 0);
        waitc(1);
        chk({tag, " R8 drive on third edge"}, bus_oe, 1);
        waitc(3);
        chk({tag, " R5 read byte"}, bus_out, exp);
        chk({tag, " R1 R5 output enabled"}, bus_oe, 1);
        if (mode) sa = 1'b0; else sa = 1'b1;
        waitc(4);
        chk({tag, " R5 bus released"}, bus_oe, 0);
        chk({tag, " R6 R7 read pulses"}, re_cnt - re0, (a < 8'd4) ? 1 : 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            regs[i] = 8'h00;
            shadow[i] = 8'h00;
        end
        // R9 reset state
        @(negedge clk);
        chk("R9 oe after reset", bus_oe, 0);
        chk("R9 we after reset", reg_we, 0);
        chk("R9 re after reset", reg_re, 0);
        chk("R9 addr after reset", reg_addr, 0);

        // R1 strobe-pair timing
        reset_mode(1'b0);
        do_write(8'h01, 8'hA5, "R1 pair");
        do_write(8'h03, 8'h3C, "R1 pair");
        do_read(8'h01, "R1 pair");
        do_read(8'h03, "R1 pair");
        do_write(8'h09, 8'hFF, "R7 pair");
        do_read(8'h09, "R7 pair");
        do_read(8'h01, "R7 pair untouched");

        // R1 data-strobe timing
        reset_mode(1'b1);
        do_write(8'h02, 8'h81, "R1 dstb");
        do_write(8'h00, 8'h7E, "R1 dstb");
        do_read(8'h02, "R1 dstb");
        do_read(8'h00, "R1 dstb");
        do_write(8'h04, 8'h11, "R7 dstb");
        do_read(8'hC0, "R7 dstb");
        do_read(8'h03, "R7 dstb untouched");

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule